// File: doc/BRIEF.md
# Compressed Immediate-Form Instruction Decoder

This block decodes one 16-bit compressed instruction parcel of the immediate-carrying class. An earlier length and mode stage supplies the parcel together with a flag that says the stream is currently in 16-bit mode. The decoder first decides whether the parcel belongs to the immediate class. If it does, the decoder produces an operation code, a target or data register number, a base or source register number, and a 64-bit immediate or byte offset that is already sign-extended, scaled and biased. Integer adds, compares, algebraic right shifts and loads and stores are covered. The loads and stores come in stack-relative and register-relative forms, for integer and floating-point registers. Execution is not part of this block, and neither is re-expansion to 32-bit encodings.

Bit numbering runs from the most significant end. Bit k of the instruction is `parcel[15-k]`. Bit 0 is the N flag, bit 15 is the M flag, bits 5-7 are the major opcode, bit 8 is the minor opcode, bits 9-11 are the register field and bits 12-14 are the low immediate field. Bits 1-4 hold selector bits, a second register and high immediate bits, depending on the operation. The outputs are registered, so a parcel presented before a rising edge is reported after that edge.

Top module: `cimm_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears the outputs on the next edge. `valid_imm` and `illegal` go to 0, `op` goes to OP_NONE and `rt`, `ra` and `imm64` go to zero, whatever the parcel is.
- R2: The outputs describe the parcel and mode flag that were sampled at the previous rising edge. Back-to-back parcels are each decoded on their own.
- R3: The immediate class is active only when all of these hold: `mode16`=1, bit 0=1, bit 15=1, and bits 5-8 are not 0011. Otherwise `valid_imm`=0, `illegal`=0, `op`=OP_NONE and all fields are zero.
- R4: Major/minor 001.0 with bit 1=0 is OP_SRADI. Its shift amount is {bits 2-4, bits 12-14}. With bit 1=1 and bit 2=0 it is OP_SRAWI, with shift amount {bits 3-4, bits 12-14}. `imm64` is the shift amount, zero-extended. `rt`=`ra`=the register field.
- R5: Major/minor 001.0 with bits 1 and 2 both 1 is OP_ADDIS. `imm64` is the sign extension of {bits 3-4, bits 12-14, 000}. `rt`=`ra`=the register field.
- R6: Major/minor 010.0 is OP_ADDI. `imm64` is the sign extension of {bits 1-4, bits 12-14}. `rt`=`ra`=the register field.
- R7: An OP_ADDI or OP_ADDIS parcel whose register field is zero gives `valid_imm`=1 and `illegal`=1, with `op`=OP_NONE and all fields zero.
- R8: Major/minor 010.1 is a compare: OP_CMPDI when bit 1=0 and OP_CMPWI when bit 1=1. `imm64` is the sign extension of {bits 2-4, bits 12-14}. `ra`=the register field and `rt`=0.
- R9: Major/minor 011.0 is a stack load: OP_LD when bit 1=0 and OP_LW when bit 1=1. Major/minor 011.1 is a stack store: OP_STW when bit 1=0 and OP_STD when bit 1=1. For these forms `ra`=1 and `rt`=the register field. The offset is the sign extension of {bits 2-4, bits 12-14}. It is shifted left by 3 for doubleword accesses and by 2 for word accesses, and then -256 is added.
- R10: Major/minor values 100.0 to 111.1 are register-relative accesses, in this order: OP_STW, OP_STD, OP_LD, OP_LW, OP_STFS, OP_STFD, OP_LFS, OP_LFD. The offset is the sign extension of {bit 1, bits 12-14}, shifted left by 3 for doubleword or double and by 2 otherwise. For loads, `rt`=bits 2-4 and `ra`=the register field. For stores, `ra`=bits 2-4 and `rt`=the register field. Doubleword offsets always have their low three bits clear.
- R11: Major values 000 with minor 0 or 1 in the immediate class give `valid_imm`=1 and `illegal`=1, with `op`=OP_NONE and all fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| parcel | input | 16 | Instruction parcel; bit k of the instruction is parcel[15-k] |
| mode16 | input | 1 | First stage reports 16-bit mode |
| valid_imm | output | 1 | Parcel belongs to the immediate class |
| illegal | output | 1 | Immediate-class parcel is reserved or unallocated |
| op | output | 4 | Operation code (cimm_op_e) |
| rt | output | 5 | Target or store-data register |
| ra | output | 5 | Base or source register |
| imm64 | output | 64 | Sign-extended, scaled and biased immediate or offset |

## Verification
The reserved-register check for the add forms and the class gate can both act on the same parcel. An add parcel with a zero register field is sent once with the mode flag set and once with it cleared. The bench expects an illegal report in the first case and a fully quiet output in the second. The stack-relative forms fold a negative scaled offset and the fixed bias into one sum in the same cycle. The bench drives all-ones immediate fields and compares the result against hand-computed values such as -260. The parcels are driven back to back, so every result is also checked for staying in step with its own input.

// File: rtl/cimm_pkg.sv
package cimm_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 4'd0,
    OP_ADDI  = 4'd1,
    OP_ADDIS = 4'd2,
    OP_SRADI = 4'd3,
    OP_SRAWI = 4'd4,
    OP_CMPDI = 4'd5,
    OP_CMPWI = 4'd6,
    OP_LD    = 4'd7,
    OP_LW    = 4'd8,
    OP_STD   = 4'd9,
    OP_STW   = 4'd10,
    OP_LFS   = 4'd11,
    OP_LFD   = 4'd12,
    OP_STFS  = 4'd13,
    OP_STFD  = 4'd14
  } cimm_op_e;

  // Parts of the immediate, as chosen by the classifier
  typedef struct packed {
    logic [3:0] hi;     // high bits, right-aligned, zero above hlen
    logic [2:0] hlen;   // number of high bits in use (0..4)
    logic [1:0] scale;  // left shift applied after extension
    logic       sp;     // add the stack bias
    logic       zext;   // zero-extend instead of sign-extend
  } imm_ctl_t;
endpackage

// File: rtl/cimm_classify.sv
module cimm_classify
  import cimm_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int SP_REG = 1
) (
  input  logic [15:0]      parcel,
  input  logic             mode16,
  output logic             active,
  output logic             reserved,
  output cimm_op_e         op,
  output logic [REG_W-1:0] rt,
  output logic [REG_W-1:0] ra,
  output imm_ctl_t         ctl
);
  logic       n_bit, m_bit;
  logic [3:0] sel4;
  logic [3:0] majmin;
  logic [2:0] fld;

  assign n_bit  = parcel[15];
  assign sel4   = parcel[14:11];
  assign majmin = parcel[10:7];
  assign fld    = parcel[6:4];
  assign m_bit  = parcel[0];
  assign active = mode16 & n_bit & m_bit & (majmin != 4'b0011);

  always_comb begin
    reserved = 1'b0;
    op       = OP_NONE;
    rt       = '0;
    ra       = '0;
    ctl      = '0;
    if (active) begin
      case (majmin)
        4'b0000, 4'b0001: reserved = 1'b1;
        4'b0010: begin
          if (!sel4[3]) begin
            op = OP_SRADI; ctl.hi = {1'b0, sel4[2:0]}; ctl.hlen = 3'd3;
            ctl.zext = 1'b1; rt = REG_W'(fld); ra = REG_W'(fld);
          end else if (!sel4[2]) begin
            op = OP_SRAWI; ctl.hi = {2'b0, sel4[1:0]}; ctl.hlen = 3'd2;
            ctl.zext = 1'b1; rt = REG_W'(fld); ra = REG_W'(fld);
          end else if (fld == 3'd0) begin
            reserved = 1'b1;
          end else begin
            op = OP_ADDIS; ctl.hi = {2'b0, sel4[1:0]}; ctl.hlen = 3'd2;
            ctl.scale = 2'd3; rt = REG_W'(fld); ra = REG_W'(fld);
          end
        end
        4'b0100: begin
          if (fld == 3'd0) begin
            reserved = 1'b1;
          end else begin
            op = OP_ADDI; ctl.hi = sel4; ctl.hlen = 3'd4;
            rt = REG_W'(fld); ra = REG_W'(fld);
          end
        end
        4'b0101: begin
          op = sel4[3] ? OP_CMPWI : OP_CMPDI;
          ctl.hi = {1'b0, sel4[2:0]}; ctl.hlen = 3'd3;
          ra = REG_W'(fld);
        end
        4'b0110, 4'b0111: begin
          if (majmin[0]) op = sel4[3] ? OP_STD : OP_STW;
          else           op = sel4[3] ? OP_LW  : OP_LD;
          ctl.scale = ((majmin[0] ^ sel4[3]) == 1'b0) ? 2'd3 : 2'd2;
          ctl.hi = {1'b0, sel4[2:0]}; ctl.hlen = 3'd3; ctl.sp = 1'b1;
          ra = REG_W'(SP_REG); rt = REG_W'(fld);
        end
        default: begin
          // 100.0 .. 111.1 register-relative accesses
          ctl.hi = {3'b0, sel4[3]}; ctl.hlen = 3'd1;
          case (majmin[2:0])
            3'b000: begin op = OP_STW;  ctl.scale = 2'd2; end
            3'b001: begin op = OP_STD;  ctl.scale = 2'd3; end
            3'b010: begin op = OP_LD;   ctl.scale = 2'd3; end
            3'b011: begin op = OP_LW;   ctl.scale = 2'd2; end
            3'b100: begin op = OP_STFS; ctl.scale = 2'd2; end
            3'b101: begin op = OP_STFD; ctl.scale = 2'd3; end
            3'b110: begin op = OP_LFS;  ctl.scale = 2'd2; end
            default: begin op = OP_LFD; ctl.scale = 2'd3; end
          endcase
          if (majmin[1]) begin
            rt = REG_W'(sel4[2:0]); ra = REG_W'(fld);
          end else begin
            ra = REG_W'(sel4[2:0]); rt = REG_W'(fld);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cimm_imm_build.sv
module cimm_imm_build
  import cimm_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int SP_BIAS = -256
) (
  input  imm_ctl_t        ctl,
  input  logic [2:0]      lo,
  output logic [XLEN-1:0] imm
);
  localparam int RAW_W = 7;
  localparam logic [XLEN-1:0] BIAS_V = XLEN'(SP_BIAS);
  localparam logic [XLEN-1:0] ONES   = {XLEN{1'b1}};

  logic [RAW_W-1:0] raw;
  logic [2:0]       top_idx;
  logic [2:0]       width;
  logic [XLEN-1:0]  raw_z, ext, scaled;

  assign raw     = {ctl.hi, lo};
  assign width   = ctl.hlen + 3'd3;
  assign top_idx = ctl.hlen + 3'd2;
  assign raw_z   = XLEN'(raw);

  always_comb begin
    if (!ctl.zext && raw[top_idx]) ext = raw_z | (ONES << width);
    else                           ext = raw_z;
    scaled = ext << ctl.scale;
    imm    = ctl.sp ? scaled + BIAS_V : scaled;
  end
endmodule

// File: rtl/cimm_decoder.sv
module cimm_decoder
  import cimm_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int REG_W   = 5,
  parameter int SP_REG  = 1,
  parameter int SP_BIAS = -256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      parcel,
  input  logic             mode16,
  output logic             valid_imm,
  output logic             illegal,
  output logic [OP_W-1:0]  op,
  output logic [REG_W-1:0] rt,
  output logic [REG_W-1:0] ra,
  output logic [XLEN-1:0]  imm64
);
  logic             c_active, c_reserved;
  cimm_op_e         c_op;
  logic [REG_W-1:0] c_rt, c_ra;
  imm_ctl_t         c_ctl;
  logic [XLEN-1:0]  c_imm;
  logic             c_good;

  cimm_classify #(.REG_W(REG_W), .SP_REG(SP_REG)) u_classify (
    .parcel  (parcel),
    .mode16  (mode16),
    .active  (c_active),
    .reserved(c_reserved),
    .op      (c_op),
    .rt      (c_rt),
    .ra      (c_ra),
    .ctl     (c_ctl)
  );

  cimm_imm_build #(.XLEN(XLEN), .SP_BIAS(SP_BIAS)) u_imm (
    .ctl(c_ctl),
    .lo (parcel[3:1]),
    .imm(c_imm)
  );

  assign c_good = c_active & ~c_reserved;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_imm <= 1'b0;
      illegal   <= 1'b0;
      op        <= OP_NONE;
      rt        <= '0;
      ra        <= '0;
      imm64     <= '0;
    end else begin
      valid_imm <= c_active;
      illegal   <= c_reserved;
      op        <= c_op;
      rt        <= c_rt;
      ra        <= c_ra;
      imm64     <= c_good ? c_imm : '0;
    end
  end
endmodule

// File: rtl/cimm_decoder_chk.sv
module cimm_decoder_chk
  import cimm_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int REG_W  = 5,
  parameter int SP_REG = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      parcel,
  input logic             mode16,
  input logic             valid_imm,
  input logic             illegal,
  input logic [OP_W-1:0]  op,
  input logic [REG_W-1:0] ra,
  input logic [XLEN-1:0]  imm64
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_imm && !illegal && op == OP_NONE && imm64 == '0));

  // R3
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode16 || !parcel[0] || !parcel[15]) |=> (!valid_imm && !illegal));

  // R3
  excluded_minor_chk: assert property (@(posedge clk) disable iff (rst)
    (parcel[10:7] == 4'b0011) |=> !valid_imm);

  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (valid_imm && op == OP_NONE && imm64 == '0));

  // R9
  stack_base_chk: assert property (@(posedge clk) disable iff (rst)
    (mode16 && parcel[15] && parcel[0] && parcel[10:8] == 3'b011)
      |=> (valid_imm && ra == REG_W'(SP_REG)));

  // R10
  dword_align_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_imm && (op == OP_LD || op == OP_STD || op == OP_LFD || op == OP_STFD))
      |-> (imm64[2:0] == 3'b000));
endmodule

bind cimm_decoder cimm_decoder_chk #(.XLEN(XLEN), .REG_W(REG_W), .SP_REG(SP_REG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .parcel   (parcel),
  .mode16   (mode16),
  .valid_imm(valid_imm),
  .illegal  (illegal),
  .op       (op),
  .ra       (ra),
  .imm64    (imm64)
);

// File: tb/cimm_decoder_bench.sv
`timescale 1ns/1ps
module cimm_decoder_bench;
  import cimm_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] parcel = '0;
  logic        mode16 = 1'b0;
  logic        valid_imm, illegal;
  logic [3:0]  op;
  logic [4:0]  rt, ra;
  logic [63:0] imm64;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cimm_decoder u_cimm_decoder (
    .clk(clk), .rst(rst), .parcel(parcel), .mode16(mode16),
    .valid_imm(valid_imm), .illegal(illegal), .op(op),
    .rt(rt), .ra(ra), .imm64(imm64)
  );

  typedef struct {
    logic     v;
    logic     il;
    cimm_op_e o;
    int       t;
    int       a;
    longint   im;
    string    tag;
  } exp_t;

  exp_t sb[$];

  function automatic logic [15:0] mk(input logic n, input logic [3:0] b14,
                                     input logic [3:0] mm, input logic [2:0] fld,
                                     input logic [2:0] lo, input logic m);
    return {n, b14, mm, fld, lo, m};
  endfunction

  task automatic send(input logic [15:0] p, input logic m16, input logic r,
                      input logic ev, input logic eil, input cimm_op_e eo,
                      input int et, input int ea, input longint eim, input string tag);
    exp_t e;
    @(negedge clk);
    parcel = p; mode16 = m16; rst = r;
    e.v = ev; e.il = eil; e.o = eo; e.t = et; e.a = ea; e.im = eim; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic quiet(input logic [15:0] p, input logic m16, input string tag);
    send(p, m16, 1'b0, 1'b0, 1'b0, OP_NONE, 0, 0, 0, tag);
  endtask

  // Monitor: compares one scoreboard item per cycle, just after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (valid_imm !== e.v || illegal !== e.il || op !== 4'(e.o) ||
          rt !== 5'(e.t) || ra !== 5'(e.a) || imm64 !== 64'(e.im)) begin
        bad++;
        $display("FAIL %s: got v=%0b il=%0b op=%0d rt=%0d ra=%0d imm=%0d exp v=%0b il=%0b op=%0d rt=%0d ra=%0d imm=%0d",
                 e.tag, valid_imm, illegal, op, rt, ra, $signed(imm64),
                 e.v, e.il, e.o, e.t, e.a, e.im);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset holds outputs clear even with a decodable parcel present
    send(mk(1, 4'b0010, 4'b0100, 3'd5, 3'b011, 1), 1'b1, 1'b1, 0, 0, OP_NONE, 0, 0, 0, "R1 reset");
    send(mk(1, 4'b0010, 4'b0100, 3'd5, 3'b011, 1), 1'b1, 1'b1, 0, 0, OP_NONE, 0, 0, 0, "R1 reset hold");

    // R6 add-immediate, R2 back-to-back
    send(mk(1, 4'b0010, 4'b0100, 3'd5, 3'b011, 1), 1, 0, 1, 0, OP_ADDI, 5, 5, 19, "R6 addi pos");
    send(mk(1, 4'b1111, 4'b0100, 3'd7, 3'b111, 1), 1, 0, 1, 0, OP_ADDI, 7, 7, -1, "R6 R2 addi neg");
    // R7 reserved add forms
    send(mk(1, 4'b0010, 4'b0100, 3'd0, 3'b011, 1), 1, 0, 1, 1, OP_NONE, 0, 0, 0, "R7 addi field0");
    // R5 add-shifted
    send(mk(1, 4'b1110, 4'b0010, 3'd3, 3'b001, 1), 1, 0, 1, 0, OP_ADDIS, 3, 3, -120, "R5 addis");
    send(mk(1, 4'b1110, 4'b0010, 3'd0, 3'b001, 1), 1, 0, 1, 1, OP_NONE, 0, 0, 0, "R7 addis field0");
    // R4 shifts
    send(mk(1, 4'b0101, 4'b0010, 3'd4, 3'b011, 1), 1, 0, 1, 0, OP_SRADI, 4, 4, 43, "R4 sradi");
    send(mk(1, 4'b1011, 4'b0010, 3'd2, 3'b110, 1), 1, 0, 1, 0, OP_SRAWI, 2, 2, 30, "R4 srawi");
    // R8 compares
    send(mk(1, 4'b0100, 4'b0101, 3'd6, 3'b000, 1), 1, 0, 1, 0, OP_CMPDI, 0, 6, -32, "R8 cmpdi");
    send(mk(1, 4'b1011, 4'b0101, 3'd1, 3'b111, 1), 1, 0, 1, 0, OP_CMPWI, 0, 1, 31, "R8 cmpwi");
    // R9 stack-relative
    send(mk(1, 4'b0001, 4'b0110, 3'd7, 3'b010, 1), 1, 0, 1, 0, OP_LD, 7, 1, -176, "R9 sp ld");
    send(mk(1, 4'b1111, 4'b0110, 3'd0, 3'b111, 1), 1, 0, 1, 0, OP_LW, 0, 1, -260, "R9 sp lw all-ones");
    send(mk(1, 4'b0010, 4'b0111, 3'd3, 3'b000, 1), 1, 0, 1, 0, OP_STW, 3, 1, -192, "R9 sp stw");
    send(mk(1, 4'b1000, 4'b0111, 3'd5, 3'b001, 1), 1, 0, 1, 0, OP_STD, 5, 1, -248, "R9 sp std");
    // R10 register-relative
    send(mk(1, 4'b0110, 4'b1000, 3'd2, 3'b101, 1), 1, 0, 1, 0, OP_STW, 2, 6, 20, "R10 stw");
    send(mk(1, 4'b1001, 4'b1001, 3'd4, 3'b000, 1), 1, 0, 1, 0, OP_STD, 4, 1, -64, "R10 std");
    send(mk(1, 4'b0011, 4'b1010, 3'd5, 3'b111, 1), 1, 0, 1, 0, OP_LD, 3, 5, 56, "R10 ld");
    send(mk(1, 4'b1000, 4'b1011, 3'd2, 3'b001, 1), 1, 0, 1, 0, OP_LW, 0, 2, -28, "R10 lw");
    send(mk(1, 4'b0111, 4'b1100, 3'd1, 3'b010, 1), 1, 0, 1, 0, OP_STFS, 1, 7, 8, "R10 stfs");
    send(mk(1, 4'b1010, 4'b1101, 3'd6, 3'b110, 1), 1, 0, 1, 0, OP_STFD, 6, 2, -16, "R10 stfd");
    send(mk(1, 4'b0101, 4'b1110, 3'd3, 3'b011, 1), 1, 0, 1, 0, OP_LFS, 5, 3, 12, "R10 lfs");
    send(mk(1, 4'b1100, 4'b1111, 3'd0, 3'b100, 1), 1, 0, 1, 0, OP_LFD, 4, 0, -32, "R10 lfd");
    // R11 unallocated major
    send(mk(1, 4'b0110, 4'b0000, 3'd2, 3'b101, 1), 1, 0, 1, 1, OP_NONE, 0, 0, 0, "R11 major000 m0");
    send(mk(1, 4'b0000, 4'b0001, 3'd0, 3'b000, 1), 1, 0, 1, 1, OP_NONE, 0, 0, 0, "R11 major000 m1");
    // R3 gating
    quiet(mk(1, 4'b0010, 4'b0100, 3'd5, 3'b011, 1), 1'b0, "R3 mode flag low");
    quiet(mk(0, 4'b0010, 4'b0100, 3'd5, 3'b011, 1), 1'b1, "R3 N low");
    quiet(mk(1, 4'b0010, 4'b0100, 3'd5, 3'b011, 0), 1'b1, "R3 M low");
    quiet(mk(1, 4'b0010, 4'b0011, 3'd5, 3'b011, 1), 1'b1, "R3 minor 001.1");
    quiet(mk(1, 4'b0010, 4'b0100, 3'd0, 3'b011, 1), 1'b0, "R3 R7 reserved add gated off");
    // R2 a valid parcel right after a gated one
    send(mk(1, 4'b0001, 4'b0100, 3'd1, 3'b000, 1), 1, 0, 1, 0, OP_ADDI, 1, 1, 8, "R2 addi after gap");
    // R1 reset mid-stream
    send(mk(1, 4'b0001, 4'b0100, 3'd1, 3'b000, 1), 1, 1, 0, 0, OP_NONE, 0, 0, 0, "R1 mid reset");
    send(mk(1, 4'b0001, 4'b0110, 3'd7, 3'b010, 1), 1, 0, 1, 0, OP_LD, 7, 1, -176, "R2 after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule